// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare Alarm

This block keeps a free-running 48-bit count of ticks from a 32768 Hz time base. A one-cycle `tick_i` pulse on the system clock delivers each tick. The count is held in 1/32768-second units, so the whole-second value is count bits [47:15]. Bit 15 of the low word is the least significant second bit. Software reads and loads the count one 16-bit word at a time through a small synchronous register port.

There is no snapshot latch. A read never stops the counter, so software that needs a consistent 48-bit value reads all three words twice and keeps the result only when both passes agree. A 48-bit compare register uses the same three-word split as the count. When a tick brings the counter to the compare value, a sticky alarm flag is set. The flag is visible in bit 0 of a status word, is cleared by writing one to that bit, and also drives the interrupt output.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset, all three count words and all three compare words read 0, status bit 0 reads 0 and `alarm_irq_o` is low.
- R2: Each clock edge with `tick_i` high and no count-word write adds one to the 48-bit count, carrying across words. The count wraps from all ones to zero. Without a tick and without a write, the count holds.
- R3: The read map is as follows. Count words are at 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Compare words are at 0x08, 0x0a and 0x0c with the same split. Status is at 0x10, with the alarm flag in bit 0 and all other bits zero. Any other address reads 0. Reads are combinational on `addr_i`.
- R4: A write to one count word replaces only that word. The other two words keep their values.
- R5: When a count-word write and a tick fall on the same edge, the written word takes the write data. The other two words take their slices of the incremented count.
- R6: Reading any register has no effect on counting. The low word read on consecutive ticking cycles rises by exactly one each cycle.
- R7: A write to a compare word replaces only that word. The compare value changes on no other event.
- R8: The alarm flag sets on an edge where `tick_i` is high and the count's new value equals the compare value. It stays set as the count moves past the compare value. A write that loads the count to the compare value without a tick does not set it.
- R9: A compare value of zero matches only when a tick brings the count to zero, that is, on wrap from all ones. Counting up from zero after reset does not set the flag.
- R10: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear has no effect. If a clear and a set fall on the same edge, the flag ends up set.
- R11: `alarm_irq_o` equals the alarm flag (status bit 0) at all times.
- R12: After 32768 ticks from a count of zero, the low word reads 0x8000, meaning the seconds field (bits 47:15) equals 1. One tick earlier it reads 0x7fff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 1/32768 s tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| alarm_irq_o | output | 1 | Alarm interrupt, level, follows the flag |

## Verification
Two pairs of events can meet on one edge. The first pair is a tick and a software write to a count word: the bench issues a middle-word write on a ticking cycle while the low word sits at 0xffff. It then expects the written middle word alongside a low word that has carried over to zero. The second pair is an alarm set and a write-one clear: the bench loads the count to one below the compare value and sends the clear on the same cycle as the tick, then expects the flag to remain set. A behavioural model of the count, compare value and flag is stepped every clock and compared against the read data and interrupt at each falling edge, so any divergence in either collision shows up immediately.

// File: rtl/elapsed_alarm_pkg.sv
package elapsed_alarm_pkg;
  localparam int unsigned DEF_CNT_W     = 48;
  localparam int unsigned DEF_WORD_W    = 16;
  localparam int unsigned DEF_ADDR_W    = 5;
  localparam int unsigned DEF_CNT_BASE  = 'h00;
  localparam int unsigned DEF_CMP_BASE  = 'h08;
  localparam int unsigned DEF_STAT_ADDR = 'h10;
  localparam int unsigned DEF_ALARM_BIT = 0;
endpackage

// File: rtl/elapsed_counter.sv
module elapsed_counter #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NUM_WORDS = CNT_W / WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NUM_WORDS-1:0] wr_word_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     cnt_next_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // per word: write beats increment, increment beats hold
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      if (wr_word_i[w])
        cnt_d[w*WORD_W +: WORD_W] = wdata_i;
      else if (tick_i)
        cnt_d[w*WORD_W +: WORD_W] = cnt_inc[w*WORD_W +: WORD_W];
      else
        cnt_d[w*WORD_W +: WORD_W] = cnt_q[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NUM_WORDS = CNT_W / WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [CNT_W-1:0]     cnt_next_i,
  input  logic [NUM_WORDS-1:0] wr_word_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 clr_i,
  output logic [CNT_W-1:0]     cmp_o,
  output logic                 flag_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q, hit;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cmp_q[w*WORD_W +: WORD_W] <= '0;
      else if (wr_word_i[w]) cmp_q[w*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  // match only when a tick lands the count on the compare value
  assign hit = tick_i && (cnt_next_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux #(
  parameter int unsigned CNT_W     = 48,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_BASE  = 'h00,
  parameter int unsigned CMP_BASE  = 'h08,
  parameter int unsigned STAT_ADDR = 'h10,
  parameter int unsigned ALARM_BIT = 0,
  localparam int unsigned NUM_WORDS = CNT_W / WORD_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic              flag_i,
  output logic [WORD_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(CNT_BASE + 2 * w)) rdata_o = cnt_i[w*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(CMP_BASE + 2 * w)) rdata_o = cmp_i[w*WORD_W +: WORD_W];
    end
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[ALARM_BIT] = flag_i;
  end
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
  import elapsed_alarm_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned CNT_BASE  = DEF_CNT_BASE,
  parameter int unsigned CMP_BASE  = DEF_CMP_BASE,
  parameter int unsigned STAT_ADDR = DEF_STAT_ADDR,
  parameter int unsigned ALARM_BIT = DEF_ALARM_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              alarm_irq_o
);
  localparam int unsigned NUM_WORDS = CNT_W / WORD_W;

  logic [NUM_WORDS-1:0] cnt_wr, cmp_wr;
  logic                 alarm_clr;
  logic [CNT_W-1:0]     cnt_q, cnt_next, cmp_q;
  logic                 flag_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign cnt_wr[w] = wr_en_i && (addr_i == ADDR_W'(CNT_BASE + 2 * w));
    assign cmp_wr[w] = wr_en_i && (addr_i == ADDR_W'(CMP_BASE + 2 * w));
  end
  assign alarm_clr = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR)) && wdata_i[ALARM_BIT];

  elapsed_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .wr_word_i  (cnt_wr),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt_q),
    .cnt_next_o (cnt_next)
  );

  alarm_unit #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_next_i (cnt_next),
    .wr_word_i  (cmp_wr),
    .wdata_i    (wdata_i),
    .clr_i      (alarm_clr),
    .cmp_o      (cmp_q),
    .flag_o     (flag_q)
  );

  reg_read_mux #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE),
    .CMP_BASE(CMP_BASE), .STAT_ADDR(STAT_ADDR), .ALARM_BIT(ALARM_BIT)
  ) u_rd (
    .addr_i  (addr_i),
    .cnt_i   (cnt_q),
    .cmp_i   (cmp_q),
    .flag_i  (flag_q),
    .rdata_o (rdata_o)
  );

  assign alarm_irq_o = flag_q;
endmodule

// File: rtl/elapsed_alarm_chk.sv
module elapsed_alarm_chk #(
  parameter int unsigned CNT_W     = 48,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_BASE  = 'h00,
  parameter int unsigned CMP_BASE  = 'h08,
  parameter int unsigned STAT_ADDR = 'h10,
  parameter int unsigned ALARM_BIT = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              flag,
  input logic              irq
);
  localparam int unsigned NUM_WORDS = CNT_W / WORD_W;
  logic cnt_wr_any, cmp_wr_any, low_wr, clr_wr;

  always_comb begin
    cnt_wr_any = 1'b0;
    cmp_wr_any = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr_en_i && addr_i == ADDR_W'(CNT_BASE + 2 * w)) cnt_wr_any = 1'b1;
      if (wr_en_i && addr_i == ADDR_W'(CMP_BASE + 2 * w)) cmp_wr_any = 1'b1;
    end
  end
  assign low_wr = wr_en_i && addr_i == ADDR_W'(CNT_BASE);
  assign clr_wr = wr_en_i && addr_i == ADDR_W'(STAT_ADDR) && wdata_i[ALARM_BIT];

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr_any |=> cnt == $past(cnt) + CNT_W'(1));
  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_wr_any |=> $stable(cnt));
  p_low_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_wr |=> cnt[WORD_W-1:0] == $past(wdata_i));
  p_cmp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr_any |=> $stable(cmp));
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !clr_wr |=> flag);
  p_flag_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(tick_i) && cnt == $past(cmp));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !tick_i |=> !flag);
  p_irq_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> irq);
endmodule

bind elapsed_alarm_timer elapsed_alarm_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE),
  .CMP_BASE(CMP_BASE), .STAT_ADDR(STAT_ADDR), .ALARM_BIT(ALARM_BIT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .cnt     (cnt_q),
  .cmp     (cmp_q),
  .flag    (flag_q),
  .irq     (alarm_irq_o)
);

// File: tb/elapsed_alarm_timer_test.sv
module elapsed_alarm_timer_test;
  localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int errs = 0, checks = 0;
  bit done = 0, live = 0;

  longint unsigned m_cnt = 0, m_cmp = 0;
  bit m_flag = 0;

  always #5 clk = ~clk;

  elapsed_alarm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_irq_o(irq)
  );

  function automatic longint unsigned put_word(longint unsigned v, int idx, logic [15:0] d);
    longint unsigned m = 64'hFFFF << (16 * idx);
    return (v & ~m) | (longint'(d) << (16 * idx));
  endfunction

  function automatic logic [15:0] model_read(logic [4:0] a);
    for (int i = 0; i < 3; i++) begin
      if (a == 5'(2 * i))     return 16'((m_cnt >> (16 * i)) & 16'hFFFF);
      if (a == 5'(8 + 2 * i)) return 16'((m_cmp >> (16 * i)) & 16'hFFFF);
    end
    if (a == 5'h10) return {15'b0, m_flag};
    return 16'h0;
  endfunction

  // behavioural reference, stepped on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_flag = 0;
    end else begin
      longint unsigned nxt = m_cnt;
      longint unsigned ncmp = m_cmp;
      bit setf;
      if (tick) nxt = (m_cnt + 1) & MASK;
      if (we) for (int i = 0; i < 3; i++) begin
        if (addr == 5'(2 * i))     nxt  = put_word(nxt, i, wdata);
        if (addr == 5'(8 + 2 * i)) ncmp = put_word(ncmp, i, wdata);
      end
      setf = tick && (nxt == m_cmp);
      m_flag = setf || (m_flag && !(we && addr == 5'h10 && wdata[0]));
      m_cnt = nxt;
      m_cmp = ncmp;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R3 read map, R11 irq)
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R3 model read", rdata, model_read(addr));
      chk("R11 irq vs model", irq, m_flag);
    end
  end

  task automatic step(bit t, bit w, logic [4:0] a, logic [15:0] d);
    tick = t; we = w; addr = a; wdata = d;
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    step(0, 1, a, d);
  endtask

  task automatic ticks(int n);
    repeat (n) step(1, 0, 5'h00, 16'h0);
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    tick = 0; we = 0; addr = a; #1; v = rdata;
  endtask

  task automatic rd48(logic [4:0] base, output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(base, w0); rd(base + 5'd2, w1); rd(base + 5'd4, w2);
    v = {w2, w1, w0};
  endtask

  task automatic load48(logic [4:0] base, logic [47:0] v);
    wr(base, v[15:0]); wr(base + 5'd2, v[31:16]); wr(base + 5'd4, v[47:32]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] v48;
    logic [15:0] v, prev;
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1'b1; live = 1;
    step(0, 0, 5'h00, 16'h0);

    // R1 reset state
    rd48(5'h00, v48); chk("R1 count", v48, 48'h0);
    rd48(5'h08, v48); chk("R1 compare", v48, 48'h0);
    rd(5'h10, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", irq, 1'b0);

    // R2 counting and holding; R9 zero compare not hit counting up
    ticks(5);
    rd(5'h00, v); chk("R2 five ticks", v, 16'h0005);
    step(0, 0, 5'h00, 0); step(0, 0, 5'h00, 0);
    rd(5'h00, v); chk("R2 hold without tick", v, 16'h0005);
    chk("R9 no match counting from zero", irq, 1'b0);

    // R4 word writes, R2 carry across words
    wr(5'h02, 16'h1234);
    rd48(5'h00, v48); chk("R4 mid only", v48, 48'h0000_1234_0005);
    wr(5'h00, 16'hFFFE); wr(5'h04, 16'hABCD);
    rd48(5'h00, v48); chk("R4 three words", v48, 48'hABCD_1234_FFFE);
    ticks(3);
    rd48(5'h00, v48); chk("R2 carry", v48, 48'hABCD_1235_0001);

    // R3 unmapped addresses
    rd(5'h06, v); chk("R3 unmapped 06", v, 16'h0);
    rd(5'h0e, v); chk("R3 unmapped 0e", v, 16'h0);

    // R5 write and tick on the same edge
    load48(5'h00, 48'h0000_0000_FFFF);
    step(1, 1, 5'h02, 16'h0005);
    rd48(5'h00, v48); chk("R5 mid write with tick", v48, 48'h0000_0005_0000);
    step(1, 1, 5'h00, 16'h0010);
    rd48(5'h00, v48); chk("R5 low write with tick", v48, 48'h0000_0005_0010);

    // R6 reads do not freeze the counter
    rd(5'h00, prev);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 5'h00, 0);
      rd(5'h00, v); chk("R6 read while counting", v, prev + 16'd1);
      prev = v;
    end

    // R7 compare words
    load48(5'h08, 48'h1234_5678_9ABC);
    rd48(5'h08, v48); chk("R7 compare readback", v48, 48'h1234_5678_9ABC);

    // R8 match on tick, sticky past compare, no set on load
    load48(5'h00, 48'h1234_5678_9AB9);
    ticks(2); chk("R8 before match", irq, 1'b0);
    ticks(1); chk("R8 on match", irq, 1'b1);
    rd(5'h10, v); chk("R11 status bit", v, 16'h0001);
    ticks(2); chk("R8 sticky", irq, 1'b1);
    wr(5'h10, 16'h0001); chk("R10 clear", irq, 1'b0);
    load48(5'h00, 48'h1234_5678_9ABC);
    chk("R8 load equal no tick", irq, 1'b0);

    // R10 write-one-to-clear details
    load48(5'h00, 48'h1234_5678_9ABB);
    ticks(1); chk("R10 set again", irq, 1'b1);
    wr(5'h10, 16'h0000); chk("R10 zero write ignored", irq, 1'b1);
    wr(5'h10, 16'hFFFE); chk("R10 bit0 clear ignored", irq, 1'b1);
    wr(5'h10, 16'h0001); chk("R10 cleared", irq, 1'b0);
    load48(5'h00, 48'h1234_5678_9ABB);
    step(1, 1, 5'h10, 16'h0001); chk("R10 set beats clear", irq, 1'b1);
    wr(5'h10, 16'h0001);

    // R9 zero compare matches on wrap
    load48(5'h08, 48'h0);
    load48(5'h00, 48'hFFFF_FFFF_FFFD);
    ticks(2); chk("R9 before wrap", irq, 1'b0);
    ticks(1);
    rd48(5'h00, v48); chk("R2 wrap to zero", v48, 48'h0);
    chk("R9 match at zero", irq, 1'b1);

    // R12 seconds boundary
    load48(5'h08, 48'hFFFF_FFFF_0000);
    load48(5'h00, 48'h0);
    wr(5'h10, 16'h0001);
    ticks(32767);
    rd(5'h00, v); chk("R12 before second", v, 16'h7FFF);
    ticks(1);
    rd48(5'h00, v48); chk("R12 one second", v48, 48'h0000_0000_8000);
    chk("R12 seconds field", 64'(v48 >> 15), 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule